// File: doc/BRIEF.md
# CAN FD Interrupt Aggregation Hierarchy

This block gathers the interrupt conditions of a CAN FD controller that has one transmit queue (slot 0), up to 31 configurable FIFOs (slots 1 to 31) and a transmit event FIFO. It builds the interrupt tree in three layers. At the bottom are per-slot flags, which are either live copies of FIFO status levels or sticky captures of event pulses. In the middle, each flag is masked by its per-slot enable and gathered into one of four 32-bit summary vectors: receive, transmit, receive overflow and transmit attempt. At the top, each summary vector is ORed into one main flag. A transmit-event flag, an invalid-message flag and a wake-up flag sit beside the four main flags from the vectors. A single interrupt line is raised when any main flag is set and its main enable is high.

Software reaches the block through a simple register port. A write takes effect on the clock edge at which `reg_wr_i` is high. Reads are combinational from `reg_addr_i`.

The register map is as follows.

| Address | Contents |
|---|---|
| 0 | Receive enables |
| 1 | Transmit enables |
| 2 | Receive-overflow enables |
| 3 | Transmit-attempt enables |
| 4 | Control: bits 6:0 main enables, bits 11:8 transmit-event source enables |
| 5 | Receive summary, read-only |
| 6 | Transmit summary, read-only |
| 7 | Receive-overflow summary, write-1-to-clear |
| 8 | Transmit-attempt summary, write-1-to-clear |
| 9 | Status |

The main flag bits are ordered as follows: 0 receive, 1 transmit, 2 receive overflow, 3 transmit attempt, 4 transmit event, 5 invalid message, 6 wake-up. The transmit-event sources are ordered as follows: 0 full, 1 half full, 2 not empty, 3 overrun.

In the status register, bits 6:0 are the main flags and bits 11:8 are the raw transmit-event sources. Bits 5, 6 and 11 are write-1-to-clear. Every other register bit reads as zero.

Top module: `canfd_irq_hub`

## Requirements
- R1: After a synchronous active-low reset, every register at addresses 0 to 9 reads zero and `irq_o` is low.
- R2: The enable registers at addresses 0 to 4 read back the value last written. Bit 0 of the receive enables (address 0) and of the receive-overflow enables (address 2) always reads 0.
- R3: Bit n of the receive summary (address 5) equals `rx_lvl_i[n]` AND receive enable n, and follows the input in the same cycle. Bit n of the transmit summary (address 6) is formed the same way from `tx_lvl_i[n]` and transmit enable n. Bit 0 of the receive summary is always 0. Writes to addresses 5 and 6 have no effect.
- R4: A pulse on `rxov_evt_i[n]` or `txat_evt_i[n]` sets a sticky per-slot flag one clock later, whatever its enable. The summary at address 7 or 8 shows flag AND enable. Writing 1 to bit n of that address clears the flag. Overflow slot 0 never sets.
- R5: When a hardware set event and a software clear of the same flag happen in the same cycle, the flag ends up set.
- R6: The full, half-full and not-empty transmit-event sources (status bits 8, 9, 10) follow their inputs live and cannot be cleared by writes. Main bit 4 is the OR of all four sources, each ANDed with its enable at control bits 8 to 11.
- R7: A pulse on `tef_ovf_evt_i` sets the overrun source (status bit 11). The source stays set until 1 is written to status bit 11.
- R8: Main bits 0 to 3 are the OR of the receive, transmit, receive-overflow and transmit-attempt summaries. Writes to status bits 0 to 4 have no effect.
- R9: The invalid-message flag (status bit 5) sets one clock after `err_frame_evt_i` is high with any bit of `err_cause_i` set, or after `dlc_mismatch_i` is high. It does not set if `rx_esi_i` is high in that cycle. Writing 1 to status bit 5 clears it.
- R10: The wake-up flag (status bit 6) sets one clock after `bus_activity_i` is high while `sleep_i` is high. Bus activity outside sleep does not set it. Writing 1 to status bit 6 clears it.
- R11: `irq_o` is high exactly when some main flag is set and its main enable (control bits 0 to 6) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_lvl_i | input | 32 | Per-slot receive condition level |
| tx_lvl_i | input | 32 | Per-slot transmit condition level |
| rxov_evt_i | input | 32 | Per-slot receive overflow event pulses |
| txat_evt_i | input | 32 | Per-slot transmit attempt event pulses |
| tef_full_i | input | 1 | Transmit event FIFO full level |
| tef_half_i | input | 1 | Transmit event FIFO half-full level |
| tef_nempty_i | input | 1 | Transmit event FIFO not-empty level |
| tef_ovf_evt_i | input | 1 | Transmit event FIFO overrun pulse |
| err_frame_evt_i | input | 1 | An error frame was sent |
| err_cause_i | input | 5 | Error causes: CRC, stuff, form, bit, ACK |
| dlc_mismatch_i | input | 1 | DLC mismatch detected pulse |
| rx_esi_i | input | 1 | Error-state indicator of the current received message |
| bus_activity_i | input | 1 | Bus activity detected |
| sleep_i | input | 1 | Controller is in sleep mode |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Combined interrupt line |

## Verification
Two functions can fall in the same cycle: a hardware set of a sticky flag and a software write-1-to-clear of that same flag. The bench provokes this by raising a receive-overflow pulse and a write of the matching bit to address 7 on the same falling edge, and it does the same with a transmit-event overrun pulse and a write to status bit 11. It judges the result by reading the summary or status register on the next falling edge, where the flag must still be set, and then by issuing a lone clear, after which the flag must read zero.

// File: rtl/canfd_irq_pkg.sv
// Shared constants for the interrupt aggregation hierarchy: register
// addresses, main flag bit positions and transmit-event source positions.
// Assumes at most 32 slots so that one register holds a whole vector.
package canfd_irq_pkg;
    localparam int DW        = 32;
    localparam int AW        = 4;
    localparam int NUM_MAIN  = 7;
    localparam int NUM_TEF   = 4;
    localparam int TEF_LSB   = 8;

    typedef enum logic [AW-1:0] {
        A_RXEN   = 4'd0,
        A_TXEN   = 4'd1,
        A_RXOVEN = 4'd2,
        A_TXATEN = 4'd3,
        A_CTRL   = 4'd4,
        A_RXSUM  = 4'd5,
        A_TXSUM  = 4'd6,
        A_RXOVS  = 4'd7,
        A_TXATS  = 4'd8,
        A_STAT   = 4'd9
    } reg_addr_e;

    localparam int M_RX   = 0;
    localparam int M_TX   = 1;
    localparam int M_RXOV = 2;
    localparam int M_TXAT = 3;
    localparam int M_TEF  = 4;
    localparam int M_IVM  = 5;
    localparam int M_WAK  = 6;

    localparam int T_FULL = 0;
    localparam int T_HALF = 1;
    localparam int T_NEMP = 2;
    localparam int T_OVF  = 3;
endpackage

// File: rtl/irq_sticky.sv
// Vector of sticky flags: each bit sets on its set pulse and clears on a
// write-1 clear; a set in the same cycle as a clear wins.
// Assumes set and clear are synchronous single-cycle qualifiers.
module irq_sticky #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    // Hold, clear or set each flag; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= '0;
        else        flag_o <= (flag_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/irq_slot_bank.sv
// Per-slot interrupt flags and their summary vectors. Receive and transmit
// flags are live levels; overflow and attempt flags are sticky. Slot 0 is
// the transmit queue and is masked out of the receive-side vectors.
// Assumes enables arrive already registered and masked.
module irq_slot_bank #(
    parameter int NS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] rx_lvl_i,
    input  logic [NS-1:0] tx_lvl_i,
    input  logic [NS-1:0] rxov_evt_i,
    input  logic [NS-1:0] txat_evt_i,
    input  logic [NS-1:0] rx_en_i,
    input  logic [NS-1:0] tx_en_i,
    input  logic [NS-1:0] rxov_en_i,
    input  logic [NS-1:0] txat_en_i,
    input  logic [NS-1:0] rxov_clr_i,
    input  logic [NS-1:0] txat_clr_i,
    output logic [NS-1:0] rx_sum_o,
    output logic [NS-1:0] tx_sum_o,
    output logic [NS-1:0] rxov_sum_o,
    output logic [NS-1:0] txat_sum_o,
    output logic [NS-1:0] rxov_raw_o
);
    localparam logic [NS-1:0] RX_MASK = {{(NS-1){1'b1}}, 1'b0};

    logic [NS-1:0] txat_raw;

    irq_sticky #(.W(NS)) rxov_flags_i (
        .clk(clk), .rst_n(rst_n),
        .set_i(rxov_evt_i & RX_MASK), .clr_i(rxov_clr_i), .flag_o(rxov_raw_o)
    );

    irq_sticky #(.W(NS)) txat_flags_i (
        .clk(clk), .rst_n(rst_n),
        .set_i(txat_evt_i), .clr_i(txat_clr_i), .flag_o(txat_raw)
    );

    // Gate every slot flag with its enable to form the summary bits.
    for (genvar s = 0; s < NS; s++) begin : g_slot
        assign rx_sum_o[s]   = rx_lvl_i[s] & rx_en_i[s] & RX_MASK[s];
        assign tx_sum_o[s]   = tx_lvl_i[s] & tx_en_i[s];
        assign rxov_sum_o[s] = rxov_raw_o[s] & rxov_en_i[s] & RX_MASK[s];
        assign txat_sum_o[s] = txat_raw[s] & txat_en_i[s];
    end
endmodule

// File: rtl/tef_irq_unit.sv
// Transmit event FIFO interrupt sources: three live status levels and one
// sticky overrun, each gated by its enable and ORed into one flag.
// Assumes the status levels are synchronous to clk.
module tef_irq_unit
    import canfd_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               full_i,
    input  logic               half_i,
    input  logic               nempty_i,
    input  logic               ovf_evt_i,
    input  logic               ovf_clr_i,
    input  logic [NUM_TEF-1:0] en_i,
    output logic [NUM_TEF-1:0] src_o,
    output logic               flag_o
);
    logic ovf_q;

    irq_sticky #(.W(1)) ovf_flag_i (
        .clk(clk), .rst_n(rst_n),
        .set_i(ovf_evt_i), .clr_i(ovf_clr_i), .flag_o(ovf_q)
    );

    // Collect the sources in their fixed bit order.
    always_comb begin
        src_o         = '0;
        src_o[T_FULL] = full_i;
        src_o[T_HALF] = half_i;
        src_o[T_NEMP] = nempty_i;
        src_o[T_OVF]  = ovf_q;
    end

    assign flag_o = |(src_o & en_i);
endmodule

// File: rtl/canfd_irq_hub.sv
// Top of the interrupt aggregation hierarchy: enable registers, main flags,
// invalid-message and wake-up sticky flags, register read/clear port and the
// combined interrupt line. Assumes NS <= 32; reads are combinational.
module canfd_irq_hub
    import canfd_irq_pkg::*;
#(
    parameter int NS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] rx_lvl_i,
    input  logic [NS-1:0] tx_lvl_i,
    input  logic [NS-1:0] rxov_evt_i,
    input  logic [NS-1:0] txat_evt_i,
    input  logic          tef_full_i,
    input  logic          tef_half_i,
    input  logic          tef_nempty_i,
    input  logic          tef_ovf_evt_i,
    input  logic          err_frame_evt_i,
    input  logic [4:0]    err_cause_i,
    input  logic          dlc_mismatch_i,
    input  logic          rx_esi_i,
    input  logic          bus_activity_i,
    input  logic          sleep_i,
    input  logic          reg_wr_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          irq_o
);
    localparam logic [NS-1:0] RX_MASK = {{(NS-1){1'b1}}, 1'b0};

    logic [NS-1:0]       rx_en, tx_en, rxov_en, txat_en;
    logic [NUM_MAIN-1:0] main_en;
    logic [NUM_TEF-1:0]  tef_en;
    logic [NS-1:0]       rx_sum, tx_sum, rxov_sum, txat_sum, rxov_raw;
    logic [NS-1:0]       rxov_clr, txat_clr;
    logic [NUM_TEF-1:0]  tef_src;
    logic                tef_flag, ivm_flag, wak_flag;
    logic                ivm_set, wak_set, ivm_clr, wak_clr, tef_ovf_clr;
    logic [NUM_MAIN-1:0] main_flags;
    logic [NS-1:0]       wd_slots;

    assign wd_slots = reg_wdata_i[NS-1:0];

    // Enable registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en   <= '0;
            tx_en   <= '0;
            rxov_en <= '0;
            txat_en <= '0;
            main_en <= '0;
            tef_en  <= '0;
        end else if (reg_wr_i) begin
            case (reg_addr_i)
                A_RXEN:   rx_en   <= wd_slots & RX_MASK;
                A_TXEN:   tx_en   <= wd_slots;
                A_RXOVEN: rxov_en <= wd_slots & RX_MASK;
                A_TXATEN: txat_en <= wd_slots;
                A_CTRL: begin
                    main_en <= reg_wdata_i[NUM_MAIN-1:0];
                    tef_en  <= reg_wdata_i[TEF_LSB +: NUM_TEF];
                end
                default: ;
            endcase
        end
    end

    // Decode write-1-to-clear strobes.
    always_comb begin
        rxov_clr    = (reg_wr_i && reg_addr_i == A_RXOVS) ? wd_slots : '0;
        txat_clr    = (reg_wr_i && reg_addr_i == A_TXATS) ? wd_slots : '0;
        ivm_clr     = reg_wr_i && reg_addr_i == A_STAT && reg_wdata_i[M_IVM];
        wak_clr     = reg_wr_i && reg_addr_i == A_STAT && reg_wdata_i[M_WAK];
        tef_ovf_clr = reg_wr_i && reg_addr_i == A_STAT && reg_wdata_i[TEF_LSB + T_OVF];
    end

    irq_slot_bank #(.NS(NS)) slots_i (
        .clk(clk), .rst_n(rst_n),
        .rx_lvl_i(rx_lvl_i), .tx_lvl_i(tx_lvl_i),
        .rxov_evt_i(rxov_evt_i), .txat_evt_i(txat_evt_i),
        .rx_en_i(rx_en), .tx_en_i(tx_en),
        .rxov_en_i(rxov_en), .txat_en_i(txat_en),
        .rxov_clr_i(rxov_clr), .txat_clr_i(txat_clr),
        .rx_sum_o(rx_sum), .tx_sum_o(tx_sum),
        .rxov_sum_o(rxov_sum), .txat_sum_o(txat_sum),
        .rxov_raw_o(rxov_raw)
    );

    tef_irq_unit tef_i (
        .clk(clk), .rst_n(rst_n),
        .full_i(tef_full_i), .half_i(tef_half_i), .nempty_i(tef_nempty_i),
        .ovf_evt_i(tef_ovf_evt_i), .ovf_clr_i(tef_ovf_clr),
        .en_i(tef_en), .src_o(tef_src), .flag_o(tef_flag)
    );

    // Qualify the invalid-message and wake-up set conditions.
    assign ivm_set = ((err_frame_evt_i && |err_cause_i) || dlc_mismatch_i) && !rx_esi_i;
    assign wak_set = bus_activity_i && sleep_i;

    irq_sticky #(.W(1)) ivm_i (
        .clk(clk), .rst_n(rst_n), .set_i(ivm_set), .clr_i(ivm_clr), .flag_o(ivm_flag)
    );

    irq_sticky #(.W(1)) wak_i (
        .clk(clk), .rst_n(rst_n), .set_i(wak_set), .clr_i(wak_clr), .flag_o(wak_flag)
    );

    // Top layer: reduce each summary vector into its main flag.
    always_comb begin
        main_flags         = '0;
        main_flags[M_RX]   = |rx_sum;
        main_flags[M_TX]   = |tx_sum;
        main_flags[M_RXOV] = |rxov_sum;
        main_flags[M_TXAT] = |txat_sum;
        main_flags[M_TEF]  = tef_flag;
        main_flags[M_IVM]  = ivm_flag;
        main_flags[M_WAK]  = wak_flag;
    end

    assign irq_o = |(main_flags & main_en);

    // Combinational read multiplexer.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_RXEN:   reg_rdata_o[NS-1:0] = rx_en;
            A_TXEN:   reg_rdata_o[NS-1:0] = tx_en;
            A_RXOVEN: reg_rdata_o[NS-1:0] = rxov_en;
            A_TXATEN: reg_rdata_o[NS-1:0] = txat_en;
            A_CTRL: begin
                reg_rdata_o[NUM_MAIN-1:0]         = main_en;
                reg_rdata_o[TEF_LSB +: NUM_TEF]   = tef_en;
            end
            A_RXSUM:  reg_rdata_o[NS-1:0] = rx_sum;
            A_TXSUM:  reg_rdata_o[NS-1:0] = tx_sum;
            A_RXOVS:  reg_rdata_o[NS-1:0] = rxov_sum;
            A_TXATS:  reg_rdata_o[NS-1:0] = txat_sum;
            A_STAT: begin
                reg_rdata_o[NUM_MAIN-1:0]         = main_flags;
                reg_rdata_o[TEF_LSB +: NUM_TEF]   = tef_src;
            end
            default: reg_rdata_o = '0;
        endcase
    end
endmodule

// Checker for the hub: temporal properties over ports and internal flags.
// Assumes it is bound into every instance of canfd_irq_hub.
module canfd_irq_hub_chk
    import canfd_irq_pkg::*;
#(
    parameter int NS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq_o,
    input logic [NUM_MAIN-1:0] main_flags,
    input logic [NS-1:0]       rxov_evt_i,
    input logic [NS-1:0]       rxov_raw,
    input logic [NUM_TEF-1:0]  tef_src,
    input logic                ivm_flag,
    input logic                wak_flag,
    input logic                rx_esi_i,
    input logic                reg_wr_i,
    input logic [AW-1:0]       reg_addr_i,
    input logic [DW-1:0]       reg_wdata_i
);
    localparam logic [NS-1:0] RX_MASK = {{(NS-1){1'b1}}, 1'b0};

    // R11
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (main_flags != '0));

    // R5
    rxov_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rxov_evt_i & RX_MASK) != '0) |=>
        ((rxov_raw & $past(rxov_evt_i) & RX_MASK) == ($past(rxov_evt_i) & RX_MASK)));

    // R10
    wak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wak_flag && !(reg_wr_i && reg_addr_i == A_STAT && reg_wdata_i[M_WAK])) |=> wak_flag);

    // R9
    ivm_esi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ivm_flag && rx_esi_i) |=> !ivm_flag);

    // R6
    tef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tef_src == '0) |-> !main_flags[M_TEF]);

    // R4
    rxov_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rxov_raw[0]);
endmodule

bind canfd_irq_hub canfd_irq_hub_chk #(.NS(NS)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .main_flags(main_flags),
    .rxov_evt_i(rxov_evt_i), .rxov_raw(rxov_raw), .tef_src(tef_src),
    .ivm_flag(ivm_flag), .wak_flag(wak_flag), .rx_esi_i(rx_esi_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i)
);

// File: tb/canfd_irq_hub_tb_top.sv
// Scoreboard bench: driver tasks queue expected reads, a monitor compares.
module canfd_irq_hub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rx_lvl_i = '0, tx_lvl_i = '0, rxov_evt_i = '0, txat_evt_i = '0;
    logic        tef_full_i = 0, tef_half_i = 0, tef_nempty_i = 0, tef_ovf_evt_i = 0;
    logic        err_frame_evt_i = 0, dlc_mismatch_i = 0, rx_esi_i = 0;
    logic [4:0]  err_cause_i = '0;
    logic        bus_activity_i = 0, sleep_i = 0;
    logic        reg_wr_i = 0;
    logic [3:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        bit          is_irq;
        logic [3:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    always #5 clk = ~clk;

    canfd_irq_hub dut_i (.*);

    // Monitor: pop the oldest expectation and compare with the outputs.
    initial begin
        forever begin
            @(sample_ev);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq_o} : reg_rdata_o;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h",
                             it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr_i = a;
        it.is_irq = 0; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #2 -> sample_ev;
        #1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1; it.addr = 4'hF; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        #2 -> sample_ev;
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 0; reg_wdata_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        for (int a = 0; a < 10; a++) expect_rd(a[3:0], 32'h0, "R1");
        expect_irq(1'b0, "R1");

        // R2 enable readback with reserved bit 0
        wr(4'd0, 32'hFFFF_FFFF);
        expect_rd(4'd0, 32'hFFFF_FFFE, "R2");
        wr(4'd2, 32'hFFFF_FFFF);
        expect_rd(4'd2, 32'hFFFF_FFFE, "R2");
        wr(4'd4, 32'h0000_0F7F);
        expect_rd(4'd4, 32'h0000_0F7F, "R2");
        wr(4'd4, 32'h0);

        // R3 live receive summary, bit 0 reserved, read-only
        @(negedge clk); rx_lvl_i = 32'h8000_0003;
        expect_rd(4'd5, 32'h8000_0002, "R3");
        expect_rd(4'd9, 32'h0000_0001, "R8");
        expect_irq(1'b0, "R11");
        wr(4'd4, 32'h1);
        expect_irq(1'b1, "R11");
        @(negedge clk); rx_lvl_i = 32'h0;
        expect_rd(4'd5, 32'h0, "R3");
        expect_irq(1'b0, "R11");
        wr(4'd5, 32'hFFFF_FFFF);
        @(negedge clk); rx_lvl_i = 32'h20;
        expect_rd(4'd5, 32'h20, "R3");
        wr(4'd9, 32'h0000_001F);
        expect_rd(4'd9, 32'h1, "R8");
        @(negedge clk); rx_lvl_i = 32'h0;
        wr(4'd1, 32'h3);
        @(negedge clk); tx_lvl_i = 32'h6;
        expect_rd(4'd6, 32'h2, "R3");
        expect_rd(4'd9, 32'h2, "R8");
        @(negedge clk); tx_lvl_i = 32'h0;

        // R4 sticky receive overflow, slot 0 never sets
        @(negedge clk); rxov_evt_i = 32'h11;
        @(negedge clk); rxov_evt_i = 32'h0;
        expect_rd(4'd7, 32'h10, "R4");
        expect_rd(4'd7, 32'h10, "R4");
        wr(4'd7, 32'h10);
        expect_rd(4'd7, 32'h0, "R4");
        // R5 set and clear in the same cycle
        @(negedge clk); rxov_evt_i = 32'h10;
        reg_wr_i = 1; reg_addr_i = 4'd7; reg_wdata_i = 32'h10;
        @(negedge clk); rxov_evt_i = 32'h0; reg_wr_i = 0; reg_wdata_i = '0;
        expect_rd(4'd7, 32'h10, "R5");
        wr(4'd7, 32'h10);
        expect_rd(4'd7, 32'h0, "R5");

        // R4 transmit attempt masked by enable, raw retained
        wr(4'd3, 32'h1);
        @(negedge clk); txat_evt_i = 32'h5;
        @(negedge clk); txat_evt_i = 32'h0;
        expect_rd(4'd8, 32'h1, "R4");
        wr(4'd3, 32'h5);
        expect_rd(4'd8, 32'h5, "R4");
        expect_rd(4'd9, 32'h8, "R8");

        do_reset();
        // R6 live transmit-event sources and enable gating
        @(negedge clk); tef_half_i = 1;
        expect_rd(4'd9, 32'h0000_0200, "R6");
        wr(4'd9, 32'h0000_0200);
        expect_rd(4'd9, 32'h0000_0200, "R6");
        wr(4'd4, 32'h0000_0210);
        expect_rd(4'd9, 32'h0000_0210, "R6");
        expect_irq(1'b1, "R11");
        @(negedge clk); tef_half_i = 0;
        expect_rd(4'd9, 32'h0, "R6");
        expect_irq(1'b0, "R11");
        // R7 overrun sticky and clear, plus same-cycle set wins
        @(negedge clk); tef_ovf_evt_i = 1;
        @(negedge clk); tef_ovf_evt_i = 0;
        expect_rd(4'd9, 32'h0000_0800, "R7");
        @(negedge clk); tef_ovf_evt_i = 1;
        reg_wr_i = 1; reg_addr_i = 4'd9; reg_wdata_i = 32'h800;
        @(negedge clk); tef_ovf_evt_i = 0; reg_wr_i = 0; reg_wdata_i = '0;
        expect_rd(4'd9, 32'h0000_0800, "R5");
        wr(4'd9, 32'h800);
        expect_rd(4'd9, 32'h0, "R7");

        do_reset();
        // R9 invalid message rules
        @(negedge clk); err_frame_evt_i = 1; err_cause_i = 5'b00000;
        @(negedge clk); err_frame_evt_i = 0;
        expect_rd(4'd9, 32'h0, "R9");
        @(negedge clk); err_frame_evt_i = 1; err_cause_i = 5'b00001; rx_esi_i = 1;
        @(negedge clk); err_frame_evt_i = 0; rx_esi_i = 0;
        expect_rd(4'd9, 32'h0, "R9");
        @(negedge clk); err_frame_evt_i = 1;
        @(negedge clk); err_frame_evt_i = 0; err_cause_i = '0;
        expect_rd(4'd9, 32'h20, "R9");
        wr(4'd9, 32'h20);
        expect_rd(4'd9, 32'h0, "R9");
        @(negedge clk); dlc_mismatch_i = 1;
        @(negedge clk); dlc_mismatch_i = 0;
        expect_rd(4'd9, 32'h20, "R9");
        wr(4'd9, 32'h20);

        // R10 wake-up only in sleep
        @(negedge clk); bus_activity_i = 1;
        @(negedge clk); bus_activity_i = 0;
        expect_rd(4'd9, 32'h0, "R10");
        @(negedge clk); bus_activity_i = 1; sleep_i = 1;
        @(negedge clk); bus_activity_i = 0; sleep_i = 0;
        expect_rd(4'd9, 32'h40, "R10");
        wr(4'd4, 32'h20);
        expect_irq(1'b0, "R11");
        wr(4'd4, 32'h40);
        expect_irq(1'b1, "R11");
        wr(4'd9, 32'h40);
        expect_rd(4'd9, 32'h0, "R10");
        expect_irq(1'b0, "R11");

        @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule